// File: doc/BRIEF.md
# Radio Link Mode Controller

This block sequences the operating modes of a packet radio. It can act as the primary transmitter or as the primary receiver. It takes a power-up bit, a role bit, a chip-enable pin, the TX FIFO empty status and the acknowledge settings. It also takes one-cycle event strobes from the packet engine: packet sent, ACK received, packet received and ACK sent. From these it decides when the radio is powered down, idle in either standby level, transmitting or receiving.

All timing runs off a microsecond tick input. One down-counter times every timed state: start-up, RX and TX settling, the ACK wait, the retry delay and the limit on time spent in TX. The block also counts retries for the current transaction and lost packets since the last channel write. It raises sticky status flags, which feed an active-low maskable interrupt, and it pulses a pop strobe when the current payload may leave the TX FIFO.

Top module: `radio_mode_ctrl`

## Requirements
- R1: After reset `mode_o` is 0 and flags, counters and `settling_o` are 0 with `irq_no` high. Mode codes are 0 power down, 1 standby-I, 2 standby-II, 3 TX and 4 RX. From any state, `pwr_up_i` low gives mode 0 one cycle later.
- R2: When `pwr_up_i` rises, the block holds mode 0 with `settling_o` high for STARTUP_US ticks and then enters standby-I.
- R3: A transmitter (`role_rx_i`=0) leaves standby-I only when `ce_i` has been high for CE_HOLD_US ticks and the FIFO is not empty. Every TX period, including retransmissions, is preceded by SETTLE_US ticks of mode 3 with `settling_o` high.
- R4: When a packet needing no ACK is sent, `tx_pop_o` pulses and flag bit 0 (sent) sets. The next mode is standby-I if `ce_i` is low, another TX if `ce_i` is high and the FIFO is not empty, and standby-II if `ce_i` is high and the FIFO is empty.
- R5: In standby-II the block goes to TX as soon as the FIFO is not empty. It goes to standby-I if `ce_i` drops.
- R6: With `auto_ack_i`=1 and `no_ack_i`=0, a sent packet leads to mode 4: SETTLE_US ticks of settling, then an ACK wait of ACK_WAIT_US ticks. An ACK received during the wait pulses `tx_pop_o`, sets the sent flag and picks the next mode as in R4.
- R7: When the ACK wait times out and `retry_cnt_o` < `retry_limit_i`, `retry_cnt_o` increments and the block waits in standby-I for (`retry_delay_i`+1)×RETRY_UNIT_US ticks before retransmitting. Otherwise it sets flag bit 2 (max retry) and returns to standby-I with no pop, so the payload stays queued. `retry_cnt_o` clears when a new transaction starts.
- R8: `lost_cnt_o` increments, saturating, on every ACK timeout and clears on `chan_wr_i`.
- R9: TX that lasts TX_MAX_US ticks with no completion ends in standby-I and sets flag bit 3 (TX overrun).
- R10: A receiver with `ce_i` high goes through RX settling into RX. A received packet sets flag bit 1 (received). With `auto_ack_i`=1 and `no_ack_i`=0, the block settles into TX and returns to RX through RX settling after `ack_sent_i`.
- R11: `flag_clr_i` clears the flags bit by bit (write-one-to-clear). A flag set in the same cycle as its clear stays set.
- R12: `irq_no` is low exactly when some flag is set whose `flag_mask_i` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle microsecond tick |
| pwr_up_i | input | 1 | Power-up request |
| role_rx_i | input | 1 | 1 = primary receiver, 0 = primary transmitter |
| ce_i | input | 1 | Chip enable |
| txf_empty_i | input | 1 | TX FIFO empty |
| auto_ack_i | input | 1 | Auto-acknowledge enable |
| no_ack_i | input | 1 | Packet asks for no ACK (own packet when transmitting, received one when receiving) |
| retry_delay_i | input | 4 | Retry delay code |
| retry_limit_i | input | 4 | Retry limit |
| chan_wr_i | input | 1 | Channel register written |
| pkt_sent_i | input | 1 | Packet transmission finished |
| ack_rcvd_i | input | 1 | ACK received |
| pkt_rcvd_i | input | 1 | Valid packet received |
| ack_sent_i | input | 1 | ACK transmission finished |
| flag_clr_i | input | 4 | Write-one-to-clear strobes for the flags |
| flag_mask_i | input | 4 | Interrupt masks, 1 = masked |
| mode_o | output | 3 | Current mode code |
| settling_o | output | 1 | Start-up or settling in progress |
| tx_pop_o | output | 1 | Current payload done, may be popped |
| retry_cnt_o | output | 4 | Retries in current transaction |
| lost_cnt_o | output | LOST_W | Lost packets since last channel write |
| flags_o | output | 4 | [0] sent, [1] received, [2] max retry, [3] TX overrun |
| irq_no | output | 1 | Interrupt, active low |

## Verification
Status flags can be raised by the mode sequencer in the same cycle that software strobes their clear bits. The bench provokes this by asserting `pkt_sent_i` and the full clear mask on the same clock edge. It then judges at the next falling edge that the sent flag is still set and the interrupt still low. A second coincidence is a receiver packet arriving while the block picks between staying in RX and turning round to send an ACK. This is checked by the mode code and flag seen one cycle after each variant of `no_ack_i`.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
  typedef enum logic [3:0] {
    ST_OFF, ST_BOOT, ST_IDLE, ST_HOLD, ST_TXS, ST_TX, ST_RXS, ST_RX, ST_BACKOFF
  } state_e;

  typedef enum logic [2:0] {
    MD_OFF = 3'd0, MD_STBY1 = 3'd1, MD_STBY2 = 3'd2, MD_TX = 3'd3, MD_RX = 3'd4
  } mode_e;

  localparam int NFLAGS     = 4;
  localparam int FLAG_SENT  = 0;
  localparam int FLAG_RCVD  = 1;
  localparam int FLAG_MAXRT = 2;
  localparam int FLAG_TXTO  = 3;
endpackage

// File: rtl/rmc_timer.sv
module rmc_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         tick_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/rmc_retry.sv
module rmc_retry #(
  parameter int CNT_W  = 4,
  parameter int LOST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              new_txn_i,
  input  logic              retry_i,
  input  logic              loss_i,
  input  logic              chan_wr_i,
  output logic [CNT_W-1:0]  retry_cnt_o,
  output logic [LOST_W-1:0] lost_cnt_o
);
  localparam logic [LOST_W-1:0] LOST_MAX = '1;

  logic [LOST_W-1:0] lost_base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        retry_cnt_o <= '0;
    else if (new_txn_i) retry_cnt_o <= '0;
    else if (retry_i)   retry_cnt_o <= retry_cnt_o + 1'b1;
  end

  assign lost_base = chan_wr_i ? '0 : lost_cnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           lost_cnt_o <= '0;
    else if (loss_i && lost_base != LOST_MAX) lost_cnt_o <= lost_base + 1'b1;
    else                                   lost_cnt_o <= lost_base;
  end

  assert_lost_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_wr_i && !loss_i) |=> (lost_cnt_o == '0));
  assert_retry_cleared_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_txn_i |=> (retry_cnt_o == '0));
endmodule

// File: rtl/rmc_flags.sv
module rmc_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flags_o,
  output logic         irq_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr_i) | set_i;  // set wins
  end

  assign irq_no = ~|(flags_o & ~mask_i);

  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
  import rmc_pkg::*;
#(
  parameter int STARTUP_US    = 1500,
  parameter int SETTLE_US     = 130,
  parameter int CE_HOLD_US    = 10,
  parameter int ACK_WAIT_US   = 250,
  parameter int RETRY_UNIT_US = 250,
  parameter int TX_MAX_US     = 4000,
  parameter int LOST_W        = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_us_i,
  input  logic              pwr_up_i,
  input  logic              role_rx_i,
  input  logic              ce_i,
  input  logic              txf_empty_i,
  input  logic              auto_ack_i,
  input  logic              no_ack_i,
  input  logic [3:0]        retry_delay_i,
  input  logic [3:0]        retry_limit_i,
  input  logic              chan_wr_i,
  input  logic              pkt_sent_i,
  input  logic              ack_rcvd_i,
  input  logic              pkt_rcvd_i,
  input  logic              ack_sent_i,
  input  logic [3:0]        flag_clr_i,
  input  logic [3:0]        flag_mask_i,
  output logic [2:0]        mode_o,
  output logic              settling_o,
  output logic              tx_pop_o,
  output logic [3:0]        retry_cnt_o,
  output logic [LOST_W-1:0] lost_cnt_o,
  output logic [3:0]        flags_o,
  output logic              irq_no
);
  localparam int TMR_SPAN = STARTUP_US + SETTLE_US + ACK_WAIT_US + TX_MAX_US + 16 * RETRY_UNIT_US;
  localparam int TMR_W    = $clog2(TMR_SPAN + 1);
  localparam int CE_W     = $clog2(CE_HOLD_US + 1);

  state_e st_q, st_d;
  logic              tmr_done, tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic [CE_W-1:0]   ce_cnt_q;
  logic              ce_ok, need_ack, can_retry;
  logic              new_txn, retry, loss;
  logic [NFLAGS-1:0] flag_set;
  state_e            after_pkt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        ce_cnt_q <= '0;
    else if (!ce_i)                                     ce_cnt_q <= '0;
    else if (tick_us_i && ce_cnt_q < CE_W'(CE_HOLD_US)) ce_cnt_q <= ce_cnt_q + 1'b1;
  end

  assign ce_ok     = (ce_cnt_q >= CE_W'(CE_HOLD_US));
  assign need_ack  = auto_ack_i && !no_ack_i;
  assign can_retry = (retry_cnt_o < retry_limit_i);
  assign after_pkt = !ce_i ? ST_IDLE : (txf_empty_i ? ST_HOLD : ST_TXS);

  always_comb begin
    st_d     = st_q;
    new_txn  = 1'b0;
    retry    = 1'b0;
    loss     = 1'b0;
    tx_pop_o = 1'b0;
    flag_set = '0;
    if (!pwr_up_i) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:  st_d = ST_BOOT;
        ST_BOOT: if (tmr_done) st_d = ST_IDLE;
        ST_IDLE: begin
          if (role_rx_i) begin
            if (ce_i) st_d = ST_RXS;
          end else if (ce_i && !txf_empty_i && ce_ok) begin
            st_d = ST_TXS; new_txn = 1'b1;
          end
        end
        ST_HOLD: begin
          if (role_rx_i || !ce_i) st_d = ST_IDLE;
          else if (!txf_empty_i) begin st_d = ST_TXS; new_txn = 1'b1; end
        end
        ST_TXS: if (tmr_done) st_d = ST_TX;
        ST_TX: begin
          if (role_rx_i && ack_sent_i) st_d = ST_RXS;
          else if (!role_rx_i && pkt_sent_i) begin
            if (need_ack) st_d = ST_RXS;
            else begin
              tx_pop_o = 1'b1; flag_set[FLAG_SENT] = 1'b1;
              st_d = after_pkt; new_txn = (after_pkt == ST_TXS);
            end
          end else if (tmr_done) begin  // TX overrun
            st_d = ST_IDLE; flag_set[FLAG_TXTO] = 1'b1;
          end
        end
        ST_RXS: if (tmr_done) st_d = ST_RX;
        ST_RX: begin
          if (role_rx_i) begin
            if (!ce_i) st_d = ST_IDLE;
            else if (pkt_rcvd_i) begin
              flag_set[FLAG_RCVD] = 1'b1;
              if (need_ack) st_d = ST_TXS;
            end
          end else if (ack_rcvd_i) begin
            tx_pop_o = 1'b1; flag_set[FLAG_SENT] = 1'b1;
            st_d = after_pkt; new_txn = (after_pkt == ST_TXS);
          end else if (tmr_done) begin
            loss = 1'b1;
            if (can_retry) begin retry = 1'b1; st_d = ST_BACKOFF; end
            else begin flag_set[FLAG_MAXRT] = 1'b1; st_d = ST_IDLE; end
          end
        end
        ST_BACKOFF: if (tmr_done) st_d = ST_TXS;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF;
    else         st_q <= st_d;
  end

  assign tmr_load = (st_d != st_q);
  always_comb begin
    unique case (st_d)
      ST_BOOT:         tmr_val = TMR_W'(STARTUP_US - 1);
      ST_TXS, ST_RXS:  tmr_val = TMR_W'(SETTLE_US - 1);
      ST_TX:           tmr_val = TMR_W'(TX_MAX_US - 1);
      ST_RX:           tmr_val = TMR_W'(ACK_WAIT_US - 1);
      ST_BACKOFF:      tmr_val = TMR_W'((32'(retry_delay_i) + 1) * RETRY_UNIT_US - 1);
      default:         tmr_val = '0;
    endcase
  end

  rmc_timer #(.W(TMR_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .tick_i(tick_us_i), .done_o(tmr_done)
  );

  rmc_retry #(.CNT_W(4), .LOST_W(LOST_W)) u_retry (
    .clk_i, .rst_ni, .new_txn_i(new_txn), .retry_i(retry), .loss_i(loss),
    .chan_wr_i, .retry_cnt_o, .lost_cnt_o
  );

  rmc_flags #(.N(NFLAGS)) u_flags (
    .clk_i, .rst_ni, .set_i(flag_set), .clr_i(flag_clr_i), .mask_i(flag_mask_i),
    .flags_o, .irq_no
  );

  always_comb begin
    unique case (st_q)
      ST_IDLE, ST_BACKOFF: mode_o = MD_STBY1;
      ST_HOLD:             mode_o = MD_STBY2;
      ST_TXS, ST_TX:       mode_o = MD_TX;
      ST_RXS, ST_RX:       mode_o = MD_RX;
      default:             mode_o = MD_OFF;
    endcase
  end
  assign settling_o = (st_q == ST_BOOT) || (st_q == ST_TXS) || (st_q == ST_RXS);

  assert_power_down_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_up_i |=> (mode_o == MD_OFF));
  assert_backoff_counted_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BACKOFF) |-> (retry_cnt_o != 4'd0));
  assert_irq_on_sent_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flags_o[FLAG_SENT]) && !flag_mask_i[FLAG_SENT]) |-> !irq_no);
  assert_maxrt_keeps_payload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[FLAG_MAXRT]) |-> !$past(tx_pop_o));
endmodule

// File: tb/tb_radio_mode_ctrl.sv
module tb_radio_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int P_STARTUP = 6, P_SETTLE = 3, P_CEHOLD = 2, P_ACKWAIT = 5, P_UNIT = 4, P_TXMAX = 20;

  logic clk = 1'b0, rst_ni = 1'b0, tick_us_i = 1'b1;
  logic pwr_up_i = 0, role_rx_i = 0, ce_i = 0, txf_empty_i = 1, auto_ack_i = 0, no_ack_i = 0;
  logic [3:0] retry_delay_i = 4'd1, retry_limit_i = 4'd2, flag_clr_i = 0, flag_mask_i = 0;
  logic chan_wr_i = 0, pkt_sent_i = 0, ack_rcvd_i = 0, pkt_rcvd_i = 0, ack_sent_i = 0;
  logic [2:0] mode_o;
  logic settling_o, tx_pop_o, irq_no;
  logic [3:0] retry_cnt_o, flags_o, lost_cnt_o;

  int checks = 0, failures = 0, pops = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (tx_pop_o) pops++;

  radio_mode_ctrl #(.STARTUP_US(P_STARTUP), .SETTLE_US(P_SETTLE), .CE_HOLD_US(P_CEHOLD),
    .ACK_WAIT_US(P_ACKWAIT), .RETRY_UNIT_US(P_UNIT), .TX_MAX_US(P_TXMAX), .LOST_W(4)) dut (
    .clk_i(clk), .rst_ni, .tick_us_i, .pwr_up_i, .role_rx_i, .ce_i, .txf_empty_i, .auto_ack_i,
    .no_ack_i, .retry_delay_i, .retry_limit_i, .chan_wr_i, .pkt_sent_i, .ack_rcvd_i, .pkt_rcvd_i,
    .ack_sent_i, .flag_clr_i, .flag_mask_i, .mode_o, .settling_o, .tx_pop_o, .retry_cnt_o,
    .lost_cnt_o, .flags_o, .irq_no);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic dwell(output int n);
    logic [3:0] s0;
    s0 = {mode_o, settling_o};
    n = 0;
    while ({mode_o, settling_o} == s0 && n < 1000) begin n++; step(); end
  endtask

  task automatic wait_mode(int m, int s);
    int n;
    n = 0;
    while (!(mode_o == m && settling_o == s) && n < 500) begin n++; step(); end
    check("wait_mode reached", int'(n < 500), 1);
  endtask

  task automatic pulse_sent(); pkt_sent_i = 1; step(); pkt_sent_i = 0; endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, p0;
    repeat (3) step();
    rst_ni = 1; step();
    // R1 reset state
    check("R1 mode", int'(mode_o), 0);
    check("R1 flags", int'(flags_o), 0);
    check("R1 irq", int'(irq_no), 1);
    check("R1 counters", int'(retry_cnt_o) + int'(lost_cnt_o) + int'(settling_o), 0);
    // R2 start-up
    pwr_up_i = 1; step();
    check("R2 settling in power down", int'({mode_o, settling_o}), 1);
    dwell(n); check("R2 startup length", n, P_STARTUP);
    check("R2 standby-I", int'(mode_o), 1);
    // R3 CE hold then TX settling
    txf_empty_i = 0; ce_i = 1; step();
    dwell(n); check("R3 ce hold", n, P_CEHOLD);
    check("R3 tx settle", int'({mode_o, settling_o}), 7);
    dwell(n); check("R3 settle length", n, P_SETTLE);
    check("R3 in TX", int'({mode_o, settling_o}), 6);
    // R4 sent, more data queued
    pkt_sent_i = 1; #1;
    check("R4 pop", int'(tx_pop_o), 1);
    step(); pkt_sent_i = 0;
    check("R4 next packet settles", int'({mode_o, settling_o}), 7);
    check("R4 sent flag", int'(flags_o[0]), 1);
    check("R12 irq low", int'(irq_no), 0);
    dwell(n);
    // R4 sent with empty FIFO
    txf_empty_i = 1; pulse_sent();
    check("R4 standby-II", int'(mode_o), 2);
    // R5 refill in standby-II
    txf_empty_i = 0; step();
    check("R5 to TX", int'({mode_o, settling_o}), 7);
    dwell(n);
    ce_i = 0; pulse_sent();
    check("R4 ce low standby-I", int'(mode_o), 1);
    // R11 clear
    flag_clr_i = 4'hF; step(); flag_clr_i = 0;
    check("R11 cleared", int'(flags_o), 0);
    check("R12 irq high", int'(irq_no), 1);
    // R11 set and clear same cycle
    ce_i = 1; wait_mode(3, 0);
    ce_i = 0; flag_clr_i = 4'hF; pulse_sent(); flag_clr_i = 0;
    check("R11 set wins", int'(flags_o[0]), 1);
    flag_mask_i = 4'h1; #1; check("R12 masked", int'(irq_no), 1);
    flag_mask_i = 4'h0; #1; check("R12 unmasked", int'(irq_no), 0);
    flag_clr_i = 4'hF; step(); flag_clr_i = 0;
    // R6 / R7 / R8 retries
    auto_ack_i = 1; no_ack_i = 0; retry_limit_i = 4'd2; retry_delay_i = 4'd1;
    ce_i = 1; wait_mode(3, 0); ce_i = 0;
    p0 = pops;
    pulse_sent();
    check("R6 rx settle", int'({mode_o, settling_o}), 9);
    dwell(n); check("R6 rx settle length", n, P_SETTLE);
    dwell(n); check("R6 ack wait length", n, P_ACKWAIT);
    check("R7 backoff mode", int'(mode_o), 1);
    check("R7 retry 1", int'(retry_cnt_o), 1);
    check("R8 lost 1", int'(lost_cnt_o), 1);
    dwell(n); check("R7 backoff length", n, (1 + 1) * P_UNIT);
    check("R7 retransmit settle", int'({mode_o, settling_o}), 7);
    wait_mode(3, 0); pulse_sent(); wait_mode(4, 0); wait_mode(1, 0);
    check("R7 retry 2", int'(retry_cnt_o), 2);
    wait_mode(3, 0); pulse_sent(); wait_mode(4, 0); wait_mode(1, 0);
    check("R7 max retry flag", int'(flags_o[2]), 1);
    check("R7 retry held", int'(retry_cnt_o), 2);
    check("R8 lost 3", int'(lost_cnt_o), 3);
    check("R7 no pop", pops - p0, 0);
    step(); check("R7 stays standby-I", int'(mode_o), 1);
    chan_wr_i = 1; step(); chan_wr_i = 0;
    check("R8 channel write clears", int'(lost_cnt_o), 0);
    // R6 ACK received, new transaction
    flag_clr_i = 4'hF; step(); flag_clr_i = 0;
    ce_i = 1; wait_mode(3, 0);
    check("R7 new txn clears retry", int'(retry_cnt_o), 0);
    pulse_sent(); wait_mode(4, 0);
    txf_empty_i = 1; ack_rcvd_i = 1; #1;
    check("R6 pop on ack", int'(tx_pop_o), 1);
    step(); ack_rcvd_i = 0;
    check("R6 to standby-II", int'(mode_o), 2);
    check("R6 sent flag", int'(flags_o[0]), 1);
    // R9 TX overrun
    txf_empty_i = 0; wait_mode(3, 0); ce_i = 0;
    dwell(n); check("R9 TX limit", n, P_TXMAX);
    check("R9 standby-I", int'(mode_o), 1);
    check("R9 overrun flag", int'(flags_o[3]), 1);
    // R10 receiver
    flag_clr_i = 4'hF; step(); flag_clr_i = 0;
    role_rx_i = 1; ce_i = 1; step();
    check("R10 rx settle", int'({mode_o, settling_o}), 9);
    dwell(n); check("R10 settle length", n, P_SETTLE);
    no_ack_i = 1; pkt_rcvd_i = 1; step(); pkt_rcvd_i = 0;
    check("R10 stays RX", int'({mode_o, settling_o}), 8);
    check("R10 received flag", int'(flags_o[1]), 1);
    no_ack_i = 0; pkt_rcvd_i = 1; step(); pkt_rcvd_i = 0;
    check("R10 ack turnaround", int'({mode_o, settling_o}), 7);
    dwell(n);
    ack_sent_i = 1; step(); ack_sent_i = 0;
    check("R10 back to RX", int'({mode_o, settling_o}), 9);
    dwell(n);
    // R1 power down from RX
    pwr_up_i = 0; step();
    check("R1 power down", int'({mode_o, settling_o}), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule